// File: doc/BRIEF.md
# Byte-Windowed Programmable Interrupt Controller

This block gathers up to 256 interrupt request lines into one prioritised request for a CPU with an 8-bit bus. Each line can be enabled or masked, and can sense either a rising edge or an active-high level. Any line that needs active-low sensing must be inverted before it reaches the block. A captured request stays pending until the CPU sends an end-of-interrupt. The CPU then reads the number of the most urgent active request. The lowest line number is the most urgent.

The CPU sees two byte-wide ports. A write to the command port selects a register and a byte lane within it. Reads and writes on the data port then move that byte of the selected register. The command value 0xFF is reserved: it retires the most urgent active request and does not change the selected register.

Top module: `pic_byte_ctrl`

## Requirements
- R1: A line whose enable bit is 0 is never captured, and it never appears in the request number or on `irq_out`.
- R2: When a line's type bit is 0 it uses edge sensing. A capture happens on a clock edge where the input is high and was low on the previous clock edge. The request then stays pending after the input falls.
- R3: When a line's type bit is 1 it uses level sensing. The line is re-captured on every clock edge where its input is high, so an end-of-interrupt sent while the input is still high leaves it pending.
- R4: Register 0 (read only) returns the lowest-numbered active request. It returns 0xFF when no request is active. A new capture is visible on `rd_data` right after the clock edge that captures it.
- R5: Command byte layout: bits [7:5] hold the register address (0 request number, 1 enable mask, 2 type mask) and bits [4:0] hold the byte lane `s`. The data port carries bits [8*s+7 : 8*s] of the selected register.
- R6: Registers 1 and 2 read back exactly what was written. Data writes to register 0 or to addresses 3 to 7 change nothing, and reads of addresses 3 to 7 return 0x00.
- R7: Writing command 0xFF clears only the lowest-numbered active request. Other pending requests stay pending.
- R8: After an end-of-interrupt, data-port writes are ignored until a new command byte is written. Data-port reads keep using the last non-0xFF command.
- R9: After reset, all enable bits, type bits and pending requests are 0. The command selects register 0, byte 0, so `rd_data` reads 0xFF.
- R10: `irq_out` is high exactly when at least one enabled request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Request inputs, active high |
| cmd_wr | input | 1 | Write strobe for the command port |
| dat_wr | input | 1 | Write strobe for the data port |
| wr_data | input | 8 | Byte written to the command or data port |
| rd_data | output | 8 | Data-port read value for the current command |
| irq_out | output | 1 | High while any enabled request is pending |

## Verification
The bench covers three end-of-interrupt cases:
- With three requests pending, it retires them one by one. A design that cleared every pending request, or the wrong one, would skip a number in the sequence 3, 9, 200, 0xFF.
- It sends an end-of-interrupt while a level line is still high. A design whose clear overrode the re-capture would drop that request.
- It follows an end-of-interrupt with a stray data write. A design that kept the old selection writable would corrupt the enable mask.

It also pulses lines that are masked, and writes to the read-only register and to unmapped addresses. A design that leaked either case would report a request or return non-zero data.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int          CMD_ADDR_W = 3;
   localparam int          CMD_SEL_W  = 5;
   localparam logic [7:0]  CMD_EOI    = 8'hFF;

   typedef enum logic [CMD_ADDR_W-1:0] {
      REG_ID   = 3'd0,
      REG_EN   = 3'd1,
      REG_TYPE = 3'd2
   } reg_sel_e;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
   parameter int NUM_LINES = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_in,
   input  logic [NUM_LINES-1:0] en_mask,
   input  logic [NUM_LINES-1:0] type_mask,
   input  logic [NUM_LINES-1:0] clr_vec,
   output logic [NUM_LINES-1:0] pending
);
   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] pend_d;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit;
      always_comb begin
         if (type_mask[i]) hit = req_in[i];
         else              hit = req_in[i] & ~prev_q[i];
         pend_d[i] = (pend_q[i] & ~clr_vec[i]) | (en_mask[i] & hit);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= req_in;
         pend_q <= pend_d;
      end
   end

   assign pending = pend_q;
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int NUM_LINES = 256,
   parameter int ID_W      = 8
) (
   input  logic [NUM_LINES-1:0] act_vec,
   output logic [ID_W-1:0]      top_id
);
   always_comb begin
      top_id = '1;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (act_vec[i]) top_id = ID_W'(i);
      end
   end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 256,
   parameter int ID_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic                 dat_wr,
   input  logic [7:0]           wr_data,
   input  logic [ID_W-1:0]      top_id,
   output logic [NUM_LINES-1:0] en_mask,
   output logic [NUM_LINES-1:0] type_mask,
   output logic                 eoi,
   output logic                 cmd_valid,
   output logic [7:0]           rd_data
);
   localparam int NUM_BYTES = NUM_LINES / 8;

   reg_sel_e             addr_q;
   logic [CMD_SEL_W-1:0] sel_q;
   logic                 valid_q;
   logic [NUM_LINES-1:0] en_q;
   logic [NUM_LINES-1:0] ty_q;
   int                   base;
   logic                 sel_ok;

   assign base   = int'(sel_q) * 8;
   assign sel_ok = int'(sel_q) < NUM_BYTES;
   assign eoi    = cmd_wr && (wr_data == CMD_EOI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= REG_ID;
         sel_q   <= '0;
         valid_q <= 1'b0;
         en_q    <= '0;
         ty_q    <= '0;
      end else if (cmd_wr) begin
         if (wr_data == CMD_EOI) begin
            valid_q <= 1'b0;
         end else begin
            addr_q  <= reg_sel_e'(wr_data[7:CMD_SEL_W]);
            sel_q   <= wr_data[CMD_SEL_W-1:0];
            valid_q <= 1'b1;
         end
      end else if (dat_wr && valid_q && sel_ok) begin
         case (addr_q)
            REG_EN:   en_q[base +: 8] <= wr_data;
            REG_TYPE: ty_q[base +: 8] <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data = 8'h00;
      case (addr_q)
         REG_ID:   rd_data = 8'(top_id);
         REG_EN:   if (sel_ok) rd_data = en_q[base +: 8];
         REG_TYPE: if (sel_ok) rd_data = ty_q[base +: 8];
         default:  rd_data = 8'h00;
      endcase
   end

   assign en_mask   = en_q;
   assign type_mask = ty_q;
   assign cmd_valid = valid_q;
endmodule

// File: rtl/pic_byte_ctrl.sv
module pic_byte_ctrl #(
   parameter int NUM_LINES = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 cmd_wr,
   input  logic                 dat_wr,
   input  logic [7:0]           wr_data,
   output logic [7:0]           rd_data,
   output logic                 irq_out
);
   localparam int ID_W = 8;

   if ((NUM_LINES % 8) != 0 || NUM_LINES < 8 || NUM_LINES > 256) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 8 between 8 and 256");
   end

   logic [NUM_LINES-1:0] en_mask;
   logic [NUM_LINES-1:0] type_mask;
   logic [NUM_LINES-1:0] pend_vec;
   logic [NUM_LINES-1:0] active_vec;
   logic [NUM_LINES-1:0] clr_vec;
   logic [ID_W-1:0]      top_id;
   logic                 eoi_pulse;
   logic                 cmd_valid;

   assign active_vec = pend_vec & en_mask;
   assign irq_out    = |active_vec;
   assign clr_vec    = (eoi_pulse && irq_out) ? (NUM_LINES'(1) << top_id) : '0;

   pic_regs #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
      .wr_data(wr_data), .top_id(top_id), .en_mask(en_mask),
      .type_mask(type_mask), .eoi(eoi_pulse), .cmd_valid(cmd_valid),
      .rd_data(rd_data)
   );

   pic_capture #(.NUM_LINES(NUM_LINES)) u_capture (
      .clk(clk), .rst_n(rst_n), .req_in(irq_in), .en_mask(en_mask),
      .type_mask(type_mask), .clr_vec(clr_vec), .pending(pend_vec)
   );

   pic_prio #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_prio (
      .act_vec(active_vec), .top_id(top_id)
   );
endmodule

// File: rtl/pic_byte_ctrl_checker.sv
module pic_byte_ctrl_checker #(
   parameter int NUM_LINES = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dat_wr,
   input logic                 irq_out,
   input logic [NUM_LINES-1:0] active,
   input logic [NUM_LINES-1:0] en_mask,
   input logic [7:0]           top_id,
   input logic                 eoi,
   input logic                 cmd_valid
);
   // R4: idle code when nothing is active
   assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> top_id == 8'hFF);

   // R4: the reported line is really active
   assert_top_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> active[top_id]);

   // R4: no lower-numbered line is active
   assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((active & ((NUM_LINES'(1) << top_id) - NUM_LINES'(1))) == '0));

   // R8: an end-of-interrupt closes the data window
   assert_eoi_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !cmd_valid);

   // R8: data writes with a closed window leave the enable mask alone
   assert_closed_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !cmd_valid) |=> $stable(en_mask));

   // R9: masks start cleared
   assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (en_mask == '0 && !irq_out));
endmodule

bind pic_byte_ctrl pic_byte_ctrl_checker #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .irq_out(irq_out),
   .active(active_vec), .en_mask(en_mask), .top_id(top_id),
   .eoi(eoi_pulse), .cmd_valid(cmd_valid)
);

// File: tb/pic_byte_ctrl_bench.sv
`timescale 1ns/1ps
module pic_byte_ctrl_bench;
   localparam int NL = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic          cmd_wr = 1'b0;
   logic          dat_wr = 1'b0;
   logic [7:0]    wr_data = 8'h00;
   logic [7:0]    rd_data;
   logic          irq_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pic_byte_ctrl #(.NUM_LINES(NL)) u_pic_byte_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_wr(cmd_wr),
      .dat_wr(dat_wr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
   );

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic do_cmd(input logic [7:0] b);
      @(negedge clk); cmd_wr = 1'b1; wr_data = b;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic do_dat(input logic [7:0] b);
      @(negedge clk); dat_wr = 1'b1; wr_data = b;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic pulse(input int line);
      @(negedge clk); irq_in[line] = 1'b1;
      @(negedge clk); irq_in[line] = 1'b0;
   endtask

   task automatic t_reset;
      check(rd_data, 8'hFF, "R9 reset id");
      check({7'd0, irq_out}, 8'h00, "R10 reset irq_out");
      do_cmd(8'h20);
      check(rd_data, 8'h00, "R9 reset enable byte0");
      do_cmd(8'h5F);
      check(rd_data, 8'h00, "R9 reset type byte31");
   endtask

   task automatic t_regs;
      do_cmd(8'h23); do_dat(8'h5A);
      check(rd_data, 8'h5A, "R5 enable byte3 readback");
      do_cmd(8'h5F); do_dat(8'h81);
      check(rd_data, 8'h81, "R6 type byte31 readback");
      do_cmd(8'h23);
      check(rd_data, 8'h5A, "R5 enable byte3 kept");
      do_cmd(8'h00); do_dat(8'h12);
      check(rd_data, 8'hFF, "R6 write to id ignored");
      do_cmd(8'h60); do_dat(8'h77);
      check(rd_data, 8'h00, "R6 unmapped reads zero");
   endtask

   task automatic t_disabled;
      do_cmd(8'h00);
      pulse(40);
      check(rd_data, 8'hFF, "R1 masked edge line");
      @(negedge clk); irq_in[255] = 1'b1;
      @(negedge clk);
      check({7'd0, irq_out}, 8'h00, "R1 masked level line");
      irq_in[255] = 1'b0;
   endtask

   task automatic t_edge;
      do_cmd(8'h21); do_dat(8'h02);
      do_cmd(8'h00);
      pulse(9);
      check(rd_data, 8'h09, "R2 edge captured");
      @(negedge clk);
      check(rd_data, 8'h09, "R2 stays after fall");
      check({7'd0, irq_out}, 8'h01, "R10 irq_out high");
   endtask

   task automatic t_priority;
      do_cmd(8'h20); do_dat(8'h08);
      do_cmd(8'h39); do_dat(8'h01);
      do_cmd(8'h00);
      @(negedge clk); irq_in[3] = 1'b1; irq_in[200] = 1'b1;
      @(negedge clk); irq_in[3] = 1'b0; irq_in[200] = 1'b0;
      check(rd_data, 8'h03, "R4 lowest first");
      do_cmd(8'hFF);
      check(rd_data, 8'h09, "R7 eoi clears one");
      do_cmd(8'hFF);
      check(rd_data, 8'hC8, "R7 second eoi");
      do_cmd(8'hFF);
      check(rd_data, 8'hFF, "R4 idle after last eoi");
      check({7'd0, irq_out}, 8'h00, "R10 irq_out low");
   endtask

   task automatic t_level;
      do_cmd(8'h26); do_dat(8'h04);
      do_cmd(8'h46); do_dat(8'h04);
      do_cmd(8'h00);
      @(negedge clk); irq_in[50] = 1'b1;
      @(negedge clk);
      check(rd_data, 8'h32, "R3 level captured");
      do_cmd(8'hFF);
      check(rd_data, 8'h32, "R3 re-latched after eoi");
      @(negedge clk); irq_in[50] = 1'b0;
      do_cmd(8'hFF);
      check(rd_data, 8'hFF, "R3 cleared after drop");
   endtask

   task automatic t_window;
      do_cmd(8'h26);
      check(rd_data, 8'h04, "R8 enable byte6");
      do_cmd(8'hFF);
      check(rd_data, 8'h04, "R8 read keeps selection");
      do_dat(8'h00);
      do_cmd(8'h26);
      check(rd_data, 8'h04, "R8 write after eoi ignored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_disabled();
      t_edge();
      t_priority();
      t_level();
      t_window();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule